// File: doc/BRIEF.md
# 7:1 Serializer with Forwarded Clock

This block turns parallel 7-bit words on several data lanes into serial streams. It sends two bits per fast-clock cycle. Each lane has a rising-phase bit and a falling-phase bit, and downstream double-data-rate output registers combine the pair. Seven bits do not split evenly into pairs. For that reason, each lane keeps a 14-bit frame that holds two words. A frame is sent as seven bit pairs over seven fast-clock cycles.

A forwarded clock lane goes through exactly the same buffering and sequencing logic as the data lanes. Its word is the constant `1111000`, sent first bit first. The result is a clock that is high for four bit times and low for three. Its rising edge lines up with the first bit of every data word.

Words are taken through a ready/valid handshake. The ready pulses come twice per frame, once for each word slot. When no word is offered in a slot, that slot sends the most recently accepted word again.

Top module: `ser7_fwdclk_tx`

## Requirements
- R1: `word_ready` is high for single cycles only. It is first high in the first cycle after reset is released. The gaps between pulses alternate between 3 cycles (slot A to slot B) and 4 cycles (slot B to the next slot A), so each 7-cycle frame has slot A first and slot B second.
- R2: A word is accepted only on a rising edge where both `word_valid` and `word_ready` are high. A `word_valid` raised while `word_ready` is low has no effect on the serial outputs.
- R3: When a slot gets no word, it sends the most recently accepted word. If no word has been accepted yet, it sends all zeros.
- R4: Lane `i` takes its word from `word_data[7*i +: 7]`. Each word is sent most significant bit first. In every cycle, `lane_rise` carries the earlier bit of the pair and `lane_fall` the later one. Within a frame, the slot A word comes before the slot B word.
- R5: The clock lane (`fclk_rise`/`fclk_fall`) sends `1111000` for every data word, aligned to that word's first bit. Over a frame, the pairs are (1,1) (1,1) (0,0) (0,1) (1,1) (1,0) (0,0).
- R6: The first bit pair of a frame that holds a slot-A word accepted at edge t shows on the outputs after edge t+7. If the first accepted word came in slot B at edge t, the frame shows after edge t+4.
- R7: In reset, `word_ready` and all serial outputs are low. They stay low until the first frame that holds an accepted word begins. The clock lane starts at the first bit of that frame.
- R8: Once started, the words of consecutive slots follow each other with no idle bit times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, one bit pair per cycle |
| rst | input | 1 | Synchronous active-high reset |
| word_valid | input | 1 | A word is offered on `word_data` |
| word_ready | output | 1 | Slot pulse; the word is taken on this cycle's edge |
| word_data | input | LANES*7 | Parallel words, lane i at bits 7*i+6 down to 7*i |
| lane_rise | output | LANES | Earlier bit of each data lane's pair |
| lane_fall | output | LANES | Later bit of each data lane's pair |
| fclk_rise | output | 1 | Earlier bit of the forwarded clock pair |
| fclk_fall | output | 1 | Later bit of the forwarded clock pair |

## Verification
The properties assume that the source changes `word_valid` and `word_data` only away from the clock edge. They also assume that reset is held for at least one edge, so the frame timer starts in a known phase. The stimulus drives every input on the falling edge. Between ready pulses it raises `word_valid` with scrambled data, so the only thing that can reach the outputs is the word present during a ready cycle. The first accepted word is placed in slot B on purpose, which tests the zero fill and the shorter start latency.

// File: rtl/ser7_pkg.sv
package ser7_pkg;

  // Which word slot of the current frame the handshake is serving
  typedef enum logic [1:0] {
    SLOT_NONE = 2'd0,
    SLOT_A    = 2'd1,
    SLOT_B    = 2'd2
  } slot_e;

  // Forwarded clock word: high for the first ceil(w/2) bits sent (MSB side).
  function automatic logic [31:0] fwd_clk_word(input int unsigned w);
    logic [31:0] r;
    r = '0;
    for (int unsigned i = 0; i < w; i++) begin
      if (i >= w - (w + 1) / 2) r[i] = 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/ser7_frame_timer.sv
module ser7_frame_timer
  import ser7_pkg::*;
#(
  parameter int unsigned WORD_BITS = 7
) (
  input  logic                          clk,
  input  logic                          rst,
  output logic                          ready,
  output slot_e                         slot,
  output logic                          frame_end,
  output logic [$clog2(WORD_BITS)-1:0]  phase
);
  localparam int unsigned PW = $clog2(WORD_BITS);
  localparam logic [PW-1:0] LAST = PW'(WORD_BITS - 1);
  localparam logic [PW-1:0] MID  = PW'(WORD_BITS / 2);

  logic [PW-1:0] ph_q;
  logic [PW-1:0] ph_nxt;
  logic          rdy_q;

  always_comb begin
    ph_nxt = (ph_q == LAST) ? '0 : ph_q + 1'b1;
  end

  // Phase resets to the last position so the first edge out of reset
  // opens a fresh frame with the slot A pulse.
  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= LAST;
      rdy_q <= 1'b0;
    end else begin
      ph_q  <= ph_nxt;
      rdy_q <= (ph_nxt == '0) || (ph_nxt == MID);
    end
  end

  always_comb begin
    slot = SLOT_NONE;
    if (rdy_q) slot = (ph_q == '0) ? SLOT_A : SLOT_B;
  end

  assign ready     = rdy_q;
  assign frame_end = (ph_q == LAST);
  assign phase     = ph_q;

endmodule

// File: rtl/ser7_lane.sv
module ser7_lane
  import ser7_pkg::*;
#(
  parameter int unsigned WORD_BITS = 7
) (
  input  logic                          clk,
  input  logic                          rst,
  input  slot_e                         slot,
  input  logic                          take,
  input  logic [WORD_BITS-1:0]          word,
  input  logic                          load,
  input  logic [$clog2(WORD_BITS)-1:0]  phase,
  output logic                          q_rise,
  output logic                          q_fall
);
  localparam int unsigned PW = $clog2(WORD_BITS);
  localparam int unsigned FB = 2 * WORD_BITS;

  logic [WORD_BITS-1:0] last_q;
  logic [WORD_BITS-1:0] slot_a_q;
  logic [WORD_BITS-1:0] slot_b_q;
  logic [WORD_BITS-1:0] pick;
  logic [FB-1:0]        frame_q;
  logic [FB-1:0]        frame_d;
  logic [PW:0]          idx_r;
  logic [PW:0]          idx_f;

  assign pick = take ? word : last_q;

  // Send order: frame bit 0 goes first; each word is sent MSB first.
  always_comb begin
    for (int j = 0; j < WORD_BITS; j++) begin
      frame_d[j]             = slot_a_q[WORD_BITS-1-j];
      frame_d[WORD_BITS + j] = slot_b_q[WORD_BITS-1-j];
    end
  end

  assign idx_r = {phase, 1'b0};
  assign idx_f = {phase, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q   <= '0;
      slot_a_q <= '0;
      slot_b_q <= '0;
      frame_q  <= '0;
      q_rise   <= 1'b0;
      q_fall   <= 1'b0;
    end else begin
      if (take) last_q <= word;
      if (slot == SLOT_A) slot_a_q <= pick;
      if (slot == SLOT_B) slot_b_q <= pick;
      if (load) frame_q <= frame_d;
      q_rise <= frame_q[idx_r];
      q_fall <= frame_q[idx_f];
    end
  end

endmodule

// File: rtl/ser7_fwdclk_tx.sv
module ser7_fwdclk_tx
  import ser7_pkg::*;
#(
  parameter int unsigned LANES     = 4,
  parameter int unsigned WORD_BITS = 7
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         word_valid,
  output logic                         word_ready,
  input  logic [LANES*WORD_BITS-1:0]   word_data,
  output logic [LANES-1:0]             lane_rise,
  output logic [LANES-1:0]             lane_fall,
  output logic                         fclk_rise,
  output logic                         fclk_fall
);
  localparam int unsigned PW = $clog2(WORD_BITS);
  localparam logic [WORD_BITS-1:0] CLK_WORD = WORD_BITS'(fwd_clk_word(WORD_BITS));

  slot_e         slot;
  logic          frame_end;
  logic [PW-1:0] phase;
  logic          take;
  logic          primed;
  logic          load;

  ser7_frame_timer #(.WORD_BITS(WORD_BITS)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .ready     (word_ready),
    .slot      (slot),
    .frame_end (frame_end),
    .phase     (phase)
  );

  assign take = word_ready && word_valid;

  // Nothing is loaded for output until a word has been accepted.
  always_ff @(posedge clk) begin
    if (rst)       primed <= 1'b0;
    else if (take) primed <= 1'b1;
  end

  assign load = frame_end && primed;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ser7_lane #(.WORD_BITS(WORD_BITS)) u_lane (
      .clk    (clk),
      .rst    (rst),
      .slot   (slot),
      .take   (take),
      .word   (word_data[g*WORD_BITS +: WORD_BITS]),
      .load   (load),
      .phase  (phase),
      .q_rise (lane_rise[g]),
      .q_fall (lane_fall[g])
    );
  end

  // Clock lane: same path, fed with a constant word in every slot.
  ser7_lane #(.WORD_BITS(WORD_BITS)) u_clk_lane (
    .clk    (clk),
    .rst    (rst),
    .slot   (slot),
    .take   (word_ready),
    .word   (CLK_WORD),
    .load   (load),
    .phase  (phase),
    .q_rise (fclk_rise),
    .q_fall (fclk_fall)
  );

endmodule

// File: rtl/ser7_fwdclk_tx_chk.sv
module ser7_fwdclk_tx_chk #(
  parameter int unsigned LANES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             word_ready,
  input logic             word_valid,
  input logic [LANES-1:0] lane_rise,
  input logic [LANES-1:0] lane_fall,
  input logic             fclk_rise,
  input logic             fclk_fall,
  input logic             primed
);

  // R1: a slot pulse is followed by at least two quiet cycles
  a_r1_ready_spacing: assert property (@(posedge clk) disable iff (rst)
    word_ready |=> !word_ready ##1 !word_ready);

  // R2: an accepted word arms the output path
  a_r2_accept_primes: assert property (@(posedge clk) disable iff (rst)
    (word_ready && word_valid) |=> primed);

  // R7: serial outputs stay quiet until something has been accepted
  a_r7_quiet_start: assert property (@(posedge clk) disable iff (rst)
    !primed |-> (lane_rise == '0 && lane_fall == '0 && !fclk_rise && !fclk_fall));

  // R5: after pair (0,1) of the clock lane comes (1,1)
  a_r5_clk_mid_edge: assert property (@(posedge clk) disable iff (rst)
    (!fclk_rise && fclk_fall) |=> (fclk_rise && fclk_fall));

  // R5: after pair (1,0) come (0,0) then (1,1)
  a_r5_clk_tail: assert property (@(posedge clk) disable iff (rst)
    (fclk_rise && !fclk_fall) |=> (!fclk_rise && !fclk_fall) ##1 (fclk_rise && fclk_fall));

  // R5: a (1,1) then (0,0) is the first word's tail, followed by (0,1)
  a_r5_clk_first_tail: assert property (@(posedge clk) disable iff (rst)
    ((fclk_rise && fclk_fall) ##1 (!fclk_rise && !fclk_fall)) |=> (!fclk_rise && fclk_fall));

endmodule

bind ser7_fwdclk_tx ser7_fwdclk_tx_chk #(.LANES(LANES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .word_ready (word_ready),
  .word_valid (word_valid),
  .lane_rise  (lane_rise),
  .lane_fall  (lane_fall),
  .fclk_rise  (fclk_rise),
  .fclk_fall  (fclk_fall),
  .primed     (primed)
);

// File: tb/test_ser7_fwdclk_tx.sv
module test_ser7_fwdclk_tx;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 4;
  localparam int W = 7;
  localparam int DW = LANES * W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          word_valid = 1'b0;
  logic          word_ready;
  logic [DW-1:0] word_data = '0;
  logic [LANES-1:0] lane_rise, lane_fall;
  logic          fclk_rise, fclk_fall;

  ser7_fwdclk_tx #(.LANES(LANES), .WORD_BITS(W)) i_ser7_fwdclk_tx (
    .clk(clk), .rst(rst), .word_valid(word_valid), .word_ready(word_ready),
    .word_data(word_data), .lane_rise(lane_rise), .lane_fall(lane_fall),
    .fclk_rise(fclk_rise), .fclk_fall(fclk_fall));

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];
  int  pushed = 0, popped = 0;
  bit  started = 0, first_b = 0, drv_done = 0, finished = 0;
  int  t_acc = 0, rel_cyc = 0, last_rdy = -1, slot_no = 0;
  logic [DW-1:0] model_last = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Driver: waits for a slot, offers (or withholds) a word, pushes expected.
  task automatic do_slot(input bit v, input logic [DW-1:0] d, input bit junk);
    bit is_b;
    @(negedge clk);
    while (!word_ready) begin
      word_valid = junk;
      word_data  = junk ? ~d : '0;
      @(negedge clk);
    end
    is_b = slot_no[0];
    if (last_rdy < 0)
      chk(cyc == rel_cyc + 1, "R1", "first ready cycle", 64'(cyc), 64'(rel_cyc + 1));
    else
      chk(cyc - last_rdy == (is_b ? 3 : 4), "R1", "ready gap",
          64'(cyc - last_rdy), 64'(is_b ? 3 : 4));
    last_rdy = cyc;
    word_valid = v;
    word_data  = v ? d : ~d;
    if (v) begin
      if (!started) begin
        started = 1; first_b = is_b; t_acc = cyc + 1;
        if (is_b) begin exp_q.push_back('0); tag_q.push_back("R7"); pushed++; end
      end
      model_last = d;
    end
    if (started) begin
      exp_q.push_back(model_last);
      tag_q.push_back(!v ? "R3" : (junk ? "R2" : "R4"));
      pushed++;
    end
    slot_no++;
    @(posedge clk); #1;
    word_valid = 1'b0;
    word_data  = '0;
  endtask

  // Monitor: rebuilds words from the serial pairs and compares.
  logic [W-1:0] acc[LANES];
  logic [W-1:0] cacc = '0;
  int  nb = 0;
  bit  mon_on = 0, quiet_ok = 1;

  task automatic take_bit(input logic [LANES-1:0] b, input logic cb);
    logic [DW-1:0] got, e;
    string t;
    for (int l = 0; l < LANES; l++) acc[l] = {acc[l][W-2:0], b[l]};
    cacc = {cacc[W-2:0], cb};
    nb++;
    if (nb == W) begin
      nb = 0;
      if (exp_q.size() > 0) begin
        for (int l = 0; l < LANES; l++) got[l*W +: W] = acc[l];
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        popped++;
        chk(got == e, t, "lane word", 64'(got), 64'(e));
        chk(cacc == 7'b1111000, "R5", "clock word", 64'(cacc), 64'h78);
      end
    end
  endtask

  initial begin
    for (int l = 0; l < LANES; l++) acc[l] = '0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (!mon_on) begin
          if (fclk_rise) begin
            mon_on = 1;
            chk(quiet_ok, "R7", "outputs quiet before start", 64'(!quiet_ok), 64'd0);
            chk(cyc == t_acc + (first_b ? 4 : 7), "R6", "start latency",
                64'(cyc), 64'(t_acc + (first_b ? 4 : 7)));
            take_bit(lane_rise, fclk_rise);
            take_bit(lane_fall, fclk_fall);
          end else if (lane_rise != '0 || lane_fall != '0 || fclk_fall) begin
            quiet_ok = 0;
          end
        end else begin
          take_bit(lane_rise, fclk_rise);
          take_bit(lane_fall, fclk_fall);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(word_ready == 1'b0 && lane_rise == '0 && lane_fall == '0 && !fclk_rise && !fclk_fall,
        "R7", "reset state", {lane_rise, lane_fall, word_ready, fclk_rise, fclk_fall}, 64'd0);
    rst = 1'b0;
    rel_cyc = cyc;
    // idle slots with stray valid between pulses: nothing may start (R2)
    do_slot(0, 28'h0, 1);
    do_slot(0, 28'h0, 1);
    do_slot(0, 28'h0, 1);
    // first word lands in slot B: slot A of that frame is zero-filled
    do_slot(1, 28'hABCDEF1, 0);
    do_slot(1, {LANES*W{1'b1}}, 0);
    do_slot(1, '0, 0);
    do_slot(1, {LANES{7'b1010101}}, 1);
    do_slot(1, {LANES{7'b0101010}}, 0);
    do_slot(0, 28'h1234567, 1);   // repeat (R3)
    do_slot(0, 28'h7654321, 0);   // repeat again
    for (int k = 0; k < W; k++) do_slot(1, {LANES{7'(1 << k)}}, k[0]);
    for (int k = 0; k < 24; k++) do_slot(k % 5 != 2, DW'($urandom), k % 3 == 0);
    do_slot(1, 28'h0000001, 0);
    do_slot(0, 28'h0, 0);
    drv_done = 1;
    wait (exp_q.size() == 0);
    repeat (3) @(negedge clk);
    chk(popped == pushed, "R8", "words streamed back to back", 64'(popped), 64'(pushed));
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule